// File: doc/BRIEF.md
# Normal/Burst Block Transfer Sequencer

This block is a bus master that writes a block of words over a shared address/data bus. A request gives a start address, a word count, a starting data value and a mode. The sequencer then produces a run of bus cycles. On each cycle it raises either an address strobe together with an address, or a data strobe together with a data word.

In normal mode every word costs two cycles: an address cycle, then a data cycle. In burst mode only the first word is preceded by an address cycle. Every later word is a single data cycle, and the receiving side advances its own address. The words carry a counting pattern that starts at the given data value.

A small receiver model sits alongside the sequencer. It holds an address counter that loads on address cycles and steps after each data cycle. Its write outputs show where each word lands, so both modes can be checked against the same expected memory addresses.

Top module: `bxs_xfer_top`

## Requirements
- R1: While reset is held and on the first cycle after it, the address strobe, data strobe, done, reject and busy outputs are all low, and the address and data buses read zero.
- R2: A request is accepted on a rising edge where `start_i` is high, `busy_o` is low and `count_i` is non-zero. The first bus cycle appears on the cycle after that edge.
- R3: In normal mode (`mode_i` = 0) a transfer of N words takes 2N cycles. Address cycles and data cycles alternate, starting with an address cycle. Address cycle k carries address base+k.
- R4: In burst mode (`mode_i` = 1) a transfer of N words takes N+1 cycles. There is one address cycle carrying the base address, followed by N consecutive data cycles with no further address cycle.
- R5: Data cycle k (k counted from 0) carries the value seed+k, modulo 2^DW.
- R6: The address and data strobes are never high together. The address bus is zero whenever the address strobe is low, and the data bus is zero whenever the data strobe is low.
- R7: `done_o` is high for exactly one cycle, and that cycle is the final data cycle of the transfer.
- R8: A request with `count_i` = 0 produces a one-cycle `reject_o` pulse on the cycle after the edge that samples it, and no bus cycles.
- R9: A request raised while `busy_o` is high is ignored. The running transfer continues unchanged and no second transfer follows.
- R10: The receiver model's write address for data cycle k equals base+k in both modes. Its counter loads from the bus on an address cycle and advances by one after every data cycle.
- R11: Addresses wrap modulo 2^AW. A transfer that starts near the top of the address space continues from address zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a transfer |
| mode_i | input | 1 | 0 = normal, 1 = burst |
| base_i | input | AW | First word address |
| count_i | input | CW | Number of words |
| seed_i | input | DW | Data value of the first word |
| bus_avld_o | output | 1 | Address cycle strobe |
| bus_addr_o | output | AW | Address on address cycles, else zero |
| bus_dvld_o | output | 1 | Data cycle strobe |
| bus_data_o | output | DW | Data on data cycles, else zero |
| done_o | output | 1 | High on the final data cycle |
| reject_o | output | 1 | Pulse for a zero-count request |
| busy_o | output | 1 | Transfer in progress |
| slv_we_o | output | 1 | Receiver write enable |
| slv_waddr_o | output | AW | Receiver write address |
| slv_wdata_o | output | DW | Receiver write data |

## Verification
The embedded properties assume that the bus strobes are driven only by this sequencer, so the receiver counter never sees another master. They also assume that request fields matter only on the accepting edge. The stimulus keeps within these limits in four ways. It raises `start_i` only for one cycle at a time, and changes inputs only at the falling edge. It mixes seeded random modes, bases, seeds and counts with directed single-word, zero-count, top-of-address-space and maximum-count cases. It injects extra requests only while a transfer is running, to exercise the ignore rule.

// File: rtl/bxs_pkg.sv
// Package: shared phase encoding for the block transfer sequencer.
// Assumes: nothing; types only.
package bxs_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } bxs_phase_e;
endpackage

// File: rtl/bxs_seq_fsm.sv
// Phase controller: decides whether the next bus cycle is idle, address or data.
// Assumes: last_i reports that the current data cycle carries the final word.
module bxs_seq_fsm
    import bxs_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       mode_i,
    input  logic [CW-1:0] count_i,
    input  logic       last_i,
    output bxs_phase_e phase_o,
    output logic       accept_o,
    output logic       advance_o,
    output logic       reject_o
);
    bxs_phase_e phase_q;
    logic       burst_q;
    logic       reject_q;
    logic       zero_cnt;

    assign zero_cnt  = (count_i == '0);
    assign accept_o  = (phase_q == PH_IDLE) && start_i && !zero_cnt;
    assign advance_o = (phase_q == PH_DATA) && !last_i;
    assign phase_o   = phase_q;
    assign reject_o  = reject_q;

    // Phase sequencing and mode capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            burst_q <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: if (accept_o) begin
                    phase_q <= PH_ADDR;
                    burst_q <= mode_i;
                end
                PH_ADDR: phase_q <= PH_DATA;
                PH_DATA: begin
                    if (last_i)       phase_q <= PH_IDLE;
                    else if (burst_q) phase_q <= PH_DATA;
                    else              phase_q <= PH_ADDR;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Zero-count request flag, one cycle after the sampling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) reject_q <= 1'b0;
        else        reject_q <= (phase_q == PH_IDLE) && start_i && zero_cnt;
    end

    // R3: normal mode returns to an address cycle after a non-final word
    p_normal_realign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DATA && !last_i && !burst_q) |=> (phase_q == PH_ADDR));
    // R4: burst mode stays in data cycles after a non-final word
    p_burst_stream_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DATA && !last_i && burst_q) |=> (phase_q == PH_DATA));
    // R8: a rejected request leaves the sequencer idle
    p_reject_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reject_q |-> (phase_q == PH_IDLE));
    // R3: an address cycle is always followed by a data cycle
    p_addr_then_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_ADDR) |=> (phase_q == PH_DATA));
endmodule

// File: rtl/bxs_word_track.sv
// Word tracker: holds the current address, current data word and words left.
// Assumes: load_i only while idle; step_i only on a non-final data cycle.
module bxs_word_track #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] count_i,
    input  logic [DW-1:0] seed_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic          last_o
);
    localparam logic [CW-1:0] ONE_WORD = CW'(1);

    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [CW-1:0] left_q;

    assign addr_o = addr_q;
    assign data_o = data_q;
    assign last_o = (left_q == ONE_WORD);

    // Load on acceptance, advance once per completed non-final word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            left_q <= '0;
        end else if (load_i) begin
            addr_q <= base_i;
            data_q <= seed_i;
            left_q <= count_i;
        end else if (step_i) begin
            addr_q <= addr_q + AW'(1);
            data_q <= data_q + DW'(1);
            left_q <= left_q - ONE_WORD;
        end
    end

    // R11: the tracked address steps by one with wrap-around
    p_addr_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (addr_q == $past(addr_q) + AW'(1)));
    // R5: the data word steps by one per word
    p_data_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (data_q == $past(data_q) + DW'(1)));
endmodule

// File: rtl/bxs_bus_drive.sv
// Bus driver: turns the phase and tracked word into strobes and gated buses.
// Assumes: phase_i comes from a register, so all outputs follow registers.
module bxs_bus_drive
    import bxs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  bxs_phase_e    phase_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    input  logic          last_i,
    output logic          avld_o,
    output logic [AW-1:0] addr_o,
    output logic          dvld_o,
    output logic [DW-1:0] data_o,
    output logic          done_o,
    output logic          busy_o
);
    // Decode strobes and zero the buses outside their own cycles.
    always_comb begin
        avld_o = (phase_i == PH_ADDR);
        dvld_o = (phase_i == PH_DATA);
        addr_o = avld_o ? addr_i : '0;
        data_o = dvld_o ? data_i : '0;
        done_o = dvld_o && last_i;
        busy_o = (phase_i != PH_IDLE);
    end
endmodule

// File: rtl/bxs_slave_model.sv
// Receiver model: address counter loaded by address cycles, stepped by data cycles.
// Assumes: a data cycle is always preceded by an address cycle for its transfer.
module bxs_slave_model #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          avld_i,
    input  logic [AW-1:0] addr_i,
    input  logic          dvld_i,
    input  logic [DW-1:0] data_i,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic [DW-1:0] wdata_o
);
    logic [AW-1:0] ptr_q;

    assign we_o    = dvld_i;
    assign waddr_o = ptr_q;
    assign wdata_o = data_i;

    // Load on address cycles, post-increment after each data cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (avld_i) ptr_q <= addr_i;
        else if (dvld_i) ptr_q <= ptr_q + AW'(1);
    end

    // R10: counter takes the bus address after an address cycle
    p_slave_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        avld_i |=> (ptr_q == $past(addr_i)));
    // R10: counter advances after a data cycle
    p_slave_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dvld_i |=> (ptr_q == $past(ptr_q) + AW'(1)));
    // R6: strobes are mutually exclusive
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(avld_i && dvld_i));
endmodule

// File: rtl/bxs_xfer_top.sv
// Top: block transfer sequencer in normal or burst mode plus receiver model.
// Assumes: request fields are only meaningful on the edge that accepts them.
module bxs_xfer_top
    import bxs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_i,
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] count_i,
    input  logic [DW-1:0] seed_i,
    output logic          bus_avld_o,
    output logic [AW-1:0] bus_addr_o,
    output logic          bus_dvld_o,
    output logic [DW-1:0] bus_data_o,
    output logic          done_o,
    output logic          reject_o,
    output logic          busy_o,
    output logic          slv_we_o,
    output logic [AW-1:0] slv_waddr_o,
    output logic [DW-1:0] slv_wdata_o
);
    bxs_phase_e    phase;
    logic          accept;
    logic          advance;
    logic          last_word;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_data;

    bxs_seq_fsm #(.CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .count_i(count_i), .last_i(last_word), .phase_o(phase),
        .accept_o(accept), .advance_o(advance), .reject_o(reject_o)
    );

    bxs_word_track #(.AW(AW), .DW(DW), .CW(CW)) u_track (
        .clk(clk), .rst_n(rst_n), .load_i(accept), .step_i(advance),
        .base_i(base_i), .count_i(count_i), .seed_i(seed_i),
        .addr_o(cur_addr), .data_o(cur_data), .last_o(last_word)
    );

    bxs_bus_drive #(.AW(AW), .DW(DW)) u_drive (
        .phase_i(phase), .addr_i(cur_addr), .data_i(cur_data), .last_i(last_word),
        .avld_o(bus_avld_o), .addr_o(bus_addr_o), .dvld_o(bus_dvld_o),
        .data_o(bus_data_o), .done_o(done_o), .busy_o(busy_o)
    );

    bxs_slave_model #(.AW(AW), .DW(DW)) u_slave (
        .clk(clk), .rst_n(rst_n), .avld_i(bus_avld_o), .addr_i(bus_addr_o),
        .dvld_i(bus_dvld_o), .data_i(bus_data_o), .we_o(slv_we_o),
        .waddr_o(slv_waddr_o), .wdata_o(slv_wdata_o)
    );

    // R7: done only ever marks a data cycle
    p_done_on_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> bus_dvld_o);
    // R7: after done the bus goes idle
    p_done_then_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
    // R9: a start during a transfer does not restart the sequence
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);
endmodule

// File: tb/tb_bxs_xfer_top.sv
module tb_bxs_xfer_top;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_i;
    logic          mode_i;
    logic [AW-1:0] base_i;
    logic [CW-1:0] count_i;
    logic [DW-1:0] seed_i;
    logic          bus_avld_o, bus_dvld_o, done_o, reject_o, busy_o, slv_we_o;
    logic [AW-1:0] bus_addr_o, slv_waddr_o;
    logic [DW-1:0] bus_data_o, slv_wdata_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    bxs_xfer_top #(.AW(AW), .DW(DW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .base_i(base_i), .count_i(count_i), .seed_i(seed_i),
        .bus_avld_o(bus_avld_o), .bus_addr_o(bus_addr_o), .bus_dvld_o(bus_dvld_o),
        .bus_data_o(bus_data_o), .done_o(done_o), .reject_o(reject_o),
        .busy_o(busy_o), .slv_we_o(slv_we_o), .slv_waddr_o(slv_waddr_o),
        .slv_wdata_o(slv_wdata_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input int k);
        return b + AW'(k);
    endfunction

    function automatic logic [DW-1:0] exp_data(input logic [DW-1:0] s, input int k);
        return s + DW'(k);
    endfunction

    function automatic int exp_len(input logic m, input int n);
        return m ? n + 1 : 2 * n;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check_idle(input string req);
        check({req, " avld"}, 32'(bus_avld_o), 0);
        check({req, " dvld"}, 32'(bus_dvld_o), 0);
        check({req, " busy"}, 32'(busy_o), 0);
        check({req, " addr"}, 32'(bus_addr_o), 0);
        check({req, " data"}, 32'(bus_data_o), 0);
    endtask

    // Runs one transfer; optionally injects a request while busy (R9).
    task automatic run_xfer(input logic m, input logic [AW-1:0] b, input int n,
                            input logic [DW-1:0] s, input bit poke);
        int total;
        total = exp_len(m, n);
        @(negedge clk);
        start_i = 1'b1; mode_i = m; base_i = b; count_i = CW'(n); seed_i = s;
        @(negedge clk);
        start_i = 1'b0;
        base_i = '0; seed_i = '0; count_i = '0;
        for (int c = 0; c < total; c++) begin
            bit is_a;
            int k;
            if (m) begin is_a = (c == 0); k = (c == 0) ? 0 : c - 1; end
            else   begin is_a = (c % 2 == 0); k = c / 2; end
            check(m ? "R4 avld" : "R3 avld", 32'(bus_avld_o), 32'(is_a));
            check("R6 dvld", 32'(bus_dvld_o), 32'(!is_a));
            check("R2 busy", 32'(busy_o), 1);
            if (is_a) begin
                check(m ? "R4 addr" : "R3 addr", 32'(bus_addr_o), 32'(exp_addr(b, k)));
                check("R6 data zero", 32'(bus_data_o), 0);
            end else begin
                check("R5 data", 32'(bus_data_o), 32'(exp_data(s, k)));
                check("R6 addr zero", 32'(bus_addr_o), 0);
                check("R10 we", 32'(slv_we_o), 1);
                check("R10 waddr", 32'(slv_waddr_o), 32'(exp_addr(b, k)));
                check("R10 wdata", 32'(slv_wdata_o), 32'(exp_data(s, k)));
            end
            check("R7 done", 32'(done_o), 32'(c == total - 1));
            if (poke && c == 0) begin
                start_i = 1'b1; mode_i = !m; base_i = b + 16'h0100;
                count_i = CW'(3); seed_i = 16'hBEEF;
            end
            @(negedge clk);
            if (poke && c == 0) begin
                start_i = 1'b0; base_i = '0; seed_i = '0; count_i = '0;
            end
        end
        check_idle("R9 after transfer");
        check("R7 done low after", 32'(done_o), 0);
    endtask

    task automatic run_reject(input logic m);
        @(negedge clk);
        start_i = 1'b1; mode_i = m; base_i = 16'h1234; count_i = '0; seed_i = 16'h55;
        @(negedge clk);
        start_i = 1'b0;
        check("R8 reject pulse", 32'(reject_o), 1);
        check_idle("R8 no cycles");
        @(negedge clk);
        check("R8 reject one cycle", 32'(reject_o), 0);
        check_idle("R8 still idle");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start_i = 1'b0; mode_i = 1'b0;
        base_i = '0; count_i = '0; seed_i = '0;
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        check("R1 reject", 32'(reject_o), 0);
        check("R1 done", 32'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");

        run_xfer(1'b0, 16'h0040, 1, 16'h0001, 1'b0);   // R3 single word
        run_xfer(1'b1, 16'h0040, 1, 16'h0002, 1'b0);   // R4 single word
        run_xfer(1'b0, 16'h1000, 5, 16'hFFFE, 1'b0);   // R5 data wrap
        run_xfer(1'b1, 16'h2000, 8, 16'h0100, 1'b0);   // R4
        run_xfer(1'b0, 16'hFFFE, 4, 16'h0010, 1'b0);   // R11 wrap normal
        run_xfer(1'b1, 16'hFFFD, 6, 16'h0020, 1'b0);   // R11 wrap burst
        run_xfer(1'b1, 16'h3000, 63, 16'h7000, 1'b0);  // max count burst
        run_reject(1'b0);                              // R8
        run_reject(1'b1);                              // R8
        run_xfer(1'b0, 16'h0500, 4, 16'h0AAA, 1'b1);   // R9 normal
        run_xfer(1'b1, 16'h0600, 4, 16'h0BBB, 1'b1);   // R9 burst

        for (int t = 0; t < 40; t++) begin
            logic m;
            int n;
            m = 1'($urandom_range(0, 1));
            n = int'($urandom_range(1, 12));
            run_xfer(m, AW'($urandom), n, DW'($urandom), bit'($urandom_range(0, 1)));
            if (t % 10 == 3) run_reject(m);
        end

        @(negedge clk);
        check_idle("R1 final idle");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule